// File: doc/BRIEF.md
# Streaming Four-Point Complex DFT

This block accepts complex samples one per clock and turns every group of four into its four frequency bins. Samples arrive on a valid-qualified stream; once the fourth sample of a group is held, the block presents the bins in natural order (bin 0 first) on four back-to-back cycles. The transform is computed exactly: each input part is two's complement, the outputs are two bits wider, and only additions, subtractions and real/imaginary swaps are used. Nothing is scaled, rounded or saturated.

The block is meant for a front end that needs short spectral snapshots without a multiplier. It has no back-pressure. Input samples offered while a group's bins are still waiting or being presented are dropped. A gap in the valid stream simply pauses collection. A synchronous active-low reset throws away both a partial group and any bins that have not yet been shown.

Top module: `sdft4_stream`

## Requirements
- R1: A sample (in_re, in_im) is taken on each rising clock edge where in_valid is high, rst_n is high and the block is collecting. The first four samples taken form a group x0, x1, x2, x3, in order of arrival.
- R2: out_valid rises on the first clock edge after the edge that takes x3 and stays high for exactly four cycles. During those cycles bins 0, 1, 2 and 3 appear in that order, one per cycle.
- R3: Bin 0 is x0 + x1 + x2 + x3 and bin 2 is x0 - x1 + x2 - x3, each worked out separately on the real and imaginary parts.
- R4: Bin 1 has real part x0r + x1i - x2r - x3i and imaginary part x0i - x1r - x2i + x3r.
- R5: Bin 3 has real part x0r - x1i - x2r + x3i and imaginary part x0i + x1r - x2i - x3r.
- R6: Results are exact over the whole input range. For example, four samples of -2048 give -8192, and four of 2047 give 8188.
- R7: out_valid is low while a group is being collected, in the cycle between the last sample and bin 0, and whenever no bin is shown. While out_valid is low, out_re and out_im are both 0.
- R8: A low in_valid in the middle of a group keeps the count of samples taken so far. Collection continues with the next valid sample, with no time limit.
- R9: Samples offered on the edge just after x3 is taken, and on the edges that show bins 0 to 2, are ignored. A sample offered on the edge that ends the bin 3 cycle is taken as x0 of the next group.
- R10: rst_n sampled low on a rising edge discards a partial group and cancels any remaining bins. out_valid is 0 after that edge and stays 0 until a complete new group has been collected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The sample on in_re/in_im is offered this cycle |
| in_re | input | 12 | Real part of the sample, two's complement |
| in_im | input | 12 | Imaginary part of the sample, two's complement |
| out_valid | output | 1 | A bin is presented on out_re/out_im |
| out_re | output | 14 | Real part of the bin, two's complement, 0 when idle |
| out_im | output | 14 | Imaginary part of the bin, two's complement, 0 when idle |

## Verification
Bins 1 and 3 differ only in the sign of the swapped odd term. A design that applies +j instead of -j, or that presents bins 1 and 3 in swapped order, gives the conjugate-mirrored values, and the tone and random groups catch this. Full-scale groups of -2048 and 2047, and mixed extremes, expose an intermediate sum that is kept one bit too narrow, because it wraps to the wrong sign. A stream with in_valid held high through the whole burst shows whether samples are wrongly taken during the burst, which corrupts the next group, and whether collection restarts exactly on the edge that ends bin 3. Resets during collection and during the burst catch designs that keep a stale sample count or let the remaining bins leak out.

// File: rtl/sdft4_pkg.sv
// Package sdft4_pkg
// Holds the constants shared by the streaming four-point DFT modules.
// Assumes the group size is fixed at four: the butterfly network is
// written for exactly that size.
package sdft4_pkg;
    localparam int GRP_LEN = 4;
    localparam int SLOT_W  = $clog2(GRP_LEN);
    localparam int GROW_W  = SLOT_W;            // bits gained by the exact sum
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GRP_LEN - 1);

    typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/sdft4_collect.sv
// Module sdft4_collect
// Collects valid-qualified complex samples into a group of four.
// Gives a one-cycle grp_full pulse on the cycle after the fourth sample.
// Assumes the emitter asserts hold from that pulse until the edge that
// ends its last bin, so stored samples stay fixed while they are read.
module sdft4_collect
    import sdft4_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_re,
    input  logic signed [IN_W-1:0] in_im,
    input  logic                   hold,
    output logic                   grp_full,
    output logic signed [IN_W-1:0] smp_re [GRP_LEN],
    output logic signed [IN_W-1:0] smp_im [GRP_LEN]
);
    slot_t fill_q;
    logic  full_q;
    logic  take;

    // A sample is taken only while not held by the emitter
    assign take = in_valid && !hold;

    // Sample counter and the one-cycle group-complete pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            full_q <= 1'b0;
        end else begin
            full_q <= take && (fill_q == LAST_SLOT);
            if (take) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // Sample storage, one register pair per slot
    for (genvar k = 0; k < GRP_LEN; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (take && (fill_q == slot_t'(k))) begin
                smp_re[k] <= in_re;
                smp_im[k] <= in_im;
            end
        end
    end

    assign grp_full = full_q;
endmodule

// File: rtl/sdft4_butterfly.sv
// Module sdft4_butterfly
// Combinational radix-2x2 network for an exact four-point forward DFT.
// Stage one forms even/odd sums and differences, and stage two combines
// them. The -j twiddle on the odd difference is a swap of real and
// imaginary parts with one sign flip. Assumes OUT_W = IN_W + 2, so no
// sum can overflow.
module sdft4_butterfly
    import sdft4_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic signed [IN_W-1:0]        x_re [GRP_LEN],
    input  logic signed [IN_W-1:0]        x_im [GRP_LEN],
    output logic signed [IN_W+GROW_W-1:0] y_re [GRP_LEN],
    output logic signed [IN_W+GROW_W-1:0] y_im [GRP_LEN]
);
    localparam int MID_W = IN_W + 1;
    localparam int OUT_W = IN_W + GROW_W;

    logic signed [MID_W-1:0] xe_re [GRP_LEN];
    logic signed [MID_W-1:0] xe_im [GRP_LEN];

    // Sign-extend every input part by one bit for stage one
    for (genvar k = 0; k < GRP_LEN; k++) begin : g_ext
        assign xe_re[k] = {x_re[k][IN_W-1], x_re[k]};
        assign xe_im[k] = {x_im[k][IN_W-1], x_im[k]};
    end

    logic signed [MID_W-1:0] ev_s_re, ev_s_im, ev_d_re, ev_d_im;
    logic signed [MID_W-1:0] od_s_re, od_s_im, od_d_re, od_d_im;

    // Stage one: pairs spaced two apart
    always_comb begin
        ev_s_re = xe_re[0] + xe_re[2];
        ev_s_im = xe_im[0] + xe_im[2];
        ev_d_re = xe_re[0] - xe_re[2];
        ev_d_im = xe_im[0] - xe_im[2];
        od_s_re = xe_re[1] + xe_re[3];
        od_s_im = xe_im[1] + xe_im[3];
        od_d_re = xe_re[1] - xe_re[3];
        od_d_im = xe_im[1] - xe_im[3];
    end

    logic signed [OUT_W-1:0] es_re, es_im, ed_re, ed_im;
    logic signed [OUT_W-1:0] os_re, os_im, tw_re, tw_im;

    // Widen stage-one results and apply -j to the odd difference
    always_comb begin
        es_re = {ev_s_re[MID_W-1], ev_s_re};
        es_im = {ev_s_im[MID_W-1], ev_s_im};
        ed_re = {ev_d_re[MID_W-1], ev_d_re};
        ed_im = {ev_d_im[MID_W-1], ev_d_im};
        os_re = {od_s_re[MID_W-1], od_s_re};
        os_im = {od_s_im[MID_W-1], od_s_im};
        tw_re = {od_d_im[MID_W-1], od_d_im};
        tw_im = -{od_d_re[MID_W-1], od_d_re};
    end

    // Stage two: combine into natural-order bins
    always_comb begin
        y_re[0] = es_re + os_re;
        y_im[0] = es_im + os_im;
        y_re[2] = es_re - os_re;
        y_im[2] = es_im - os_im;
        y_re[1] = ed_re + tw_re;
        y_im[1] = ed_im + tw_im;
        y_re[3] = ed_re - tw_re;
        y_im[3] = ed_im - tw_im;
    end
endmodule

// File: rtl/sdft4_emit.sv
// Module sdft4_emit
// Registers the four bins when a group completes, then presents them one
// per cycle in natural order. The outputs are forced to zero when idle.
// Asserts busy from the load cycle until the cycle that shows the last
// bin, so the collector keeps its samples and drops new ones.
module sdft4_emit
    import sdft4_pkg::*;
#(
    parameter int OUT_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [OUT_W-1:0] bin_re [GRP_LEN],
    input  logic signed [OUT_W-1:0] bin_im [GRP_LEN],
    output logic                    busy,
    output logic                    show,
    output logic signed [OUT_W-1:0] show_re,
    output logic signed [OUT_W-1:0] show_im
);
    logic signed [OUT_W-1:0] hold_re [GRP_LEN];
    logic signed [OUT_W-1:0] hold_im [GRP_LEN];
    slot_t sel_q;
    logic  show_q;

    // Burst control: start on load, stop after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            show_q <= 1'b0;
            sel_q  <= '0;
        end else if (load) begin
            show_q <= 1'b1;
            sel_q  <= '0;
        end else if (show_q) begin
            show_q <= (sel_q != LAST_SLOT);
            sel_q  <= sel_q + 1'b1;
        end
    end

    // Bin capture registers, loaded once per group
    for (genvar k = 0; k < GRP_LEN; k++) begin : g_bin
        always_ff @(posedge clk) begin
            if (load) begin
                hold_re[k] <= bin_re[k];
                hold_im[k] <= bin_im[k];
            end
        end
    end

    // Output selection with zero when idle
    always_comb begin
        show_re = show_q ? hold_re[sel_q] : '0;
        show_im = show_q ? hold_im[sel_q] : '0;
    end

    assign busy = load || (show_q && (sel_q != LAST_SLOT));
    assign show = show_q;
endmodule

// File: rtl/sdft4_stream.sv
// Module sdft4_stream (top)
// Streaming exact four-point forward DFT: collect four samples, compute
// the bins with adders only, and present them on four consecutive cycles.
// Assumes in_re/in_im are two's complement and there is no back-pressure
// from downstream.
module sdft4_stream
    import sdft4_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + GROW_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_re,
    input  logic signed [IN_W-1:0]  in_im,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_re,
    output logic signed [OUT_W-1:0] out_im
);
    logic                    grp_full;
    logic                    busy;
    logic signed [IN_W-1:0]  smp_re [GRP_LEN];
    logic signed [IN_W-1:0]  smp_im [GRP_LEN];
    logic signed [OUT_W-1:0] bin_re [GRP_LEN];
    logic signed [OUT_W-1:0] bin_im [GRP_LEN];

    sdft4_collect #(.IN_W(IN_W)) u_collect (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_re    (in_re),
        .in_im    (in_im),
        .hold     (busy),
        .grp_full (grp_full),
        .smp_re   (smp_re),
        .smp_im   (smp_im)
    );

    sdft4_butterfly #(.IN_W(IN_W)) u_bfly (
        .x_re (smp_re),
        .x_im (smp_im),
        .y_re (bin_re),
        .y_im (bin_im)
    );

    sdft4_emit #(.OUT_W(OUT_W)) u_emit (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (grp_full),
        .bin_re  (bin_re),
        .bin_im  (bin_im),
        .busy    (busy),
        .show    (out_valid),
        .show_re (out_re),
        .show_im (out_im)
    );
endmodule

// File: rtl/sdft4_stream_chk.sv
// Module sdft4_stream_chk
// Protocol checker bound to sdft4_stream. It watches only the top-level
// ports and keeps its own count of the burst length.
module sdft4_stream_chk #(
    parameter int OUT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_re,
    input logic [OUT_W-1:0] out_im
);
    logic [2:0] run_q;

    // Number of consecutive cycles out_valid has been high
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= out_valid ? run_q + 3'd1 : 3'd0;
    end

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_re == '0) && (out_im == '0));

    // R2
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> run_q < 3'd4);

    // R2
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_valid) && $past(rst_n)) |-> run_q == 3'd4);

    // R1
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid, 2) && $past(rst_n, 2));

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

bind sdft4_stream sdft4_stream_chk #(.OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/tb_sdft4_stream.sv
`timescale 1ns / 1ps
module tb_sdft4_stream;
    localparam int IN_W  = 12;
    localparam int OUT_W = 14;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_re = '0;
    logic signed [IN_W-1:0]  in_im = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_re;
    logic signed [OUT_W-1:0] out_im;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int fr [4];
    int fi [4];
    int er [4];
    int ei [4];

    sdft4_stream #(.IN_W(IN_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
    );

    always #4 clk = ~clk;

    // Advance one edge; inputs and samples both happen 2 ns after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Bins from the four transform equations
    function automatic void calc();
        er[0] = fr[0] + fr[1] + fr[2] + fr[3];
        ei[0] = fi[0] + fi[1] + fi[2] + fi[3];
        er[1] = fr[0] + fi[1] - fr[2] - fi[3];
        ei[1] = fi[0] - fr[1] - fi[2] + fr[3];
        er[2] = fr[0] - fr[1] + fr[2] - fr[3];
        ei[2] = fi[0] - fi[1] + fi[2] - fi[3];
        er[3] = fr[0] - fi[1] - fr[2] + fi[3];
        ei[3] = fi[0] + fr[1] - fi[2] - fr[3];
    endfunction

    function automatic string bin_req(input int b);
        return (b == 1) ? "R4" : (b == 3) ? "R5" : "R3";
    endfunction

    task automatic chk_idle(input string req);
        chk({req, " out_valid"}, int'(out_valid), 0);
        chk({req, " out_re"}, int'(out_re), 0);
        chk({req, " out_im"}, int'(out_im), 0);
    endtask

    task automatic chk_bin(input int b, input string extra);
        chk({"R2 valid bin", extra}, int'(out_valid), 1);
        chk({bin_req(b), " re", extra}, int'(out_re), er[b]);
        chk({bin_req(b), " im", extra}, int'(out_im), ei[b]);
    endtask

    // Send fr/fi as one group with up to max_gap idle cycles between samples
    task automatic run_group(input int max_gap, input string extra);
        calc();
        for (int s = 0; s < 4; s++) begin
            in_valid = 1'b1; in_re = IN_W'(fr[s]); in_im = IN_W'(fi[s]);
            tick();
            in_valid = 1'b0; in_re = '0; in_im = '0;
            chk_idle("R7 collecting");
            if (max_gap > 0 && s < 3) begin
                int g = int'($urandom_range(max_gap));
                for (int q = 0; q < g; q++) begin
                    in_re = IN_W'(q + 77); in_im = IN_W'(-q - 5);
                    tick();
                    chk_idle("R8 gap");
                end
            end
        end
        tick();
        for (int b = 0; b < 4; b++) begin
            chk_bin(b, extra);
            tick();
        end
        chk_idle("R7 after burst");
    endtask

    task automatic set4(input int a0r, a0i, a1r, a1i, a2r, a2i, a3r, a3i);
        fr[0] = a0r; fi[0] = a0i; fr[1] = a1r; fi[1] = a1i;
        fr[2] = a2r; fi[2] = a2i; fr[3] = a3r; fi[3] = a3i;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int sd = 32'd9137;
        void'($urandom(sd));
        tick(); tick();
        chk_idle("R10 reset state");
        rst_n = 1'b1;
        tick();
        chk_idle("R7 idle after reset");

        set4(25, -11, 0, 0, 0, 0, 0, 0);           run_group(0, " impulse");
        set4(17, -9, 17, -9, 17, -9, 17, -9);      run_group(0, " dc");
        set4(30, 0, 0, -30, -30, 0, 0, 30);        run_group(0, " tone");
        set4(0, 30, 30, 0, 0, -30, -30, 0);        run_group(0, " tone3");
        set4(-2048, -2048, -2048, -2048, -2048, -2048, -2048, -2048);
        run_group(0, " R6 min");
        set4(2047, 2047, 2047, 2047, 2047, 2047, 2047, 2047);
        run_group(0, " R6 max");
        set4(2047, -2048, -2048, 2047, 2047, -2048, -2048, 2047);
        run_group(0, " R6 mixed");
        set4(-2048, 2047, 2047, -2048, -2048, -2048, 2047, 2047);
        run_group(0, " R6 mixed2");
        set4(8, 3, 2, -5, -7, 1, 4, 6);            run_group(3, " R8 gaps");

        // R9: in_valid held high through the burst; stream s0..s15
        begin
            int sr [16];
            int si [16];
            for (int n = 0; n < 16; n++) begin
                sr[n] = int'($urandom_range(4095)) - 2048;
                si[n] = int'($urandom_range(4095)) - 2048;
            end
            for (int n = 0; n < 16; n++) begin
                in_valid = 1'b1; in_re = IN_W'(sr[n]); in_im = IN_W'(si[n]);
                tick();
                if (n == 15) in_valid = 1'b0;
                if (n + 1 >= 5 && n + 1 <= 8) begin
                    for (int k = 0; k < 4; k++) begin fr[k] = sr[k]; fi[k] = si[k]; end
                    calc();
                    chk_bin(n + 1 - 5, " R9 first group");
                end else if (n + 1 >= 13) begin
                    for (int k = 0; k < 4; k++) begin fr[k] = sr[k + 8]; fi[k] = si[k + 8]; end
                    calc();
                    chk_bin(n + 1 - 13, " R9 restart group");
                end else begin
                    chk_idle("R9 idle window");
                end
            end
            tick();
            chk_idle("R9 after stream");
        end

        // R10: reset during collection discards the partial group
        in_valid = 1'b1; in_re = 12'sd100; in_im = -12'sd50; tick();
        in_re = -12'sd20; in_im = 12'sd7; tick();
        in_valid = 1'b0; rst_n = 1'b0; tick();
        chk_idle("R10 partial reset");
        rst_n = 1'b1;
        set4(1, 2, 3, 4, 5, 6, 7, 8);              run_group(0, " R10 after partial");

        // R10: reset during the burst cancels the remaining bins
        set4(9, -4, 6, 2, -3, 11, 5, -7);
        calc();
        for (int s = 0; s < 4; s++) begin
            in_valid = 1'b1; in_re = IN_W'(fr[s]); in_im = IN_W'(fi[s]); tick();
        end
        in_valid = 1'b0;
        tick();
        chk_bin(0, " R10 before abort");
        rst_n = 1'b0; tick();
        chk_idle("R10 abort");
        rst_n = 1'b1;
        for (int q = 0; q < 5; q++) begin
            tick();
            chk("R10 stays quiet", int'(out_valid), 0);
        end

        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < 4; k++) begin
                fr[k] = int'($urandom_range(4095)) - 2048;
                fi[k] = int'($urandom_range(4095)) - 2048;
            end
            run_group((r % 2 == 0) ? 0 : 2, " R1 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule